// File: doc/BRIEF.md
# Clock Frequency Tolerance Lock Detector

This block decides whether a recovered clock runs at the same frequency as a local reference clock, within a tolerance picked at run time. Every measurement window of a fixed number of reference cycles, it counts how many recovered-clock edges arrived. It then compares the count with the window length and declares the two clocks in tolerance when the difference is no larger than the selected allowance.

The result steers a clock-recovery unit under manual control. While not locked, the unit is held in lock-to-reference mode. After a parameterised run of consecutive good windows, the block raises its locked flag and selects lock-to-data mode. One bad window drops both again. The recovered-clock edge count crosses into the reference domain as a Gray-coded value through a two-flop synchronizer, so no multi-bit value is ever sampled mid-change.

Top module: `ppm_lock_detector`

## Requirements
- R1: While `rst` is high, and right after it falls, `freq_locked` and `lock_to_data` are 0, which selects lock-to-reference mode.
- R2: `tol_sel` picks the tolerance: 0 means 125 ppm, 1 means 250 ppm, 2 means 500 ppm and 3 means 1000 ppm. The allowance in counts is the window length times ppm divided by one million, rounded to nearest.
- R3: A window lasts 2^WIN_LOG2 reference cycles. The first window after reset only sets a baseline and is never judged. Both outputs change only in the cycle after a window ends.
- R4: Lock is declared only after LOCK_WINDOWS consecutive windows in which |count − 2^WIN_LOG2| is within the selected allowance.
- R5: A single window that is out of tolerance clears `freq_locked` and returns the unit to lock-to-reference mode.
- R6: `lock_to_data` is 1 (data mode) exactly when `freq_locked` is 1.
- R7: A stopped recovered clock counts as out of tolerance. It drops an existing lock and prevents a new one.
- R8: `tol_sel` is read at each window's judgement, so tightening it while locked drops the lock at the next window end if the offset exceeds the new allowance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all outputs are in this domain |
| rec_clk | input | 1 | Recovered clock whose frequency is measured |
| rst | input | 1 | Asynchronous active-high reset, synchronized into each domain |
| tol_sel | input | 2 | Tolerance select: 0=125, 1=250, 2=500, 3=1000 ppm |
| freq_locked | output | 1 | Frequencies agree within tolerance for the required run |
| lock_to_data | output | 1 | 1 selects lock-to-data, 0 selects lock-to-reference |

## Verification
The bench builds the block with WIN_LOG2=12 and LOCK_WINDOWS=2. With these values the allowances become 1, 1, 2 and 4 counts, and a full lock, loss and relock cycle takes only a few thousand reference cycles. Recovered-clock periods offset by about ±750 ppm and +2000 ppm fall clearly inside or outside each allowance. A table of such offsets paired with each select value can therefore be walked in one run. Directed tests then cover the baseline window, the consecutive-window count, tightening the select while locked, a stopped recovered clock and a reset while locked.

// File: rtl/ppm_lock_detector.sv
module ppm_lock_detector #(
  parameter int WIN_LOG2     = 16,
  parameter int LOCK_WINDOWS = 4
) (
  input  logic       ref_clk,
  input  logic       rec_clk,
  input  logic       rst,
  input  logic [1:0] tol_sel,
  output logic       freq_locked,
  output logic       lock_to_data
);

  localparam int CNT_W  = WIN_LOG2 + 2;
  localparam int GOOD_W = $clog2(LOCK_WINDOWS + 1);
  localparam longint WIN = longint'(1) << WIN_LOG2;
  localparam longint TOL0 = (WIN * 125  + 500000) / 1000000;
  localparam longint TOL1 = (WIN * 250  + 500000) / 1000000;
  localparam longint TOL2 = (WIN * 500  + 500000) / 1000000;
  localparam longint TOL3 = (WIN * 1000 + 500000) / 1000000;
  localparam logic [CNT_W:0] WIN_EXT = (CNT_W+1)'(WIN);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_WINDOWS);

  // recovered-clock domain: reset synchronizer and Gray counter
  logic [1:0]       rec_rst_q;
  logic             rec_rst;
  logic [CNT_W-1:0] rec_bin, rec_gray;

  always_ff @(posedge rec_clk or posedge rst)
    if (rst) rec_rst_q <= 2'b11;
    else     rec_rst_q <= {rec_rst_q[0], 1'b0};
  assign rec_rst = rec_rst_q[1];

  always_ff @(posedge rec_clk or posedge rec_rst)
    if (rec_rst) begin
      rec_bin  <= '0;
      rec_gray <= '0;
    end else begin
      rec_bin  <= rec_bin + 1'b1;
      rec_gray <= (rec_bin + 1'b1) ^ ((rec_bin + 1'b1) >> 1);
    end

  // reference domain
  logic [1:0]          ref_rst_q;
  logic                ref_rst;
  logic [CNT_W-1:0]    gray_s1, gray_s2, cur_bin, prev_bin, delta;
  logic [WIN_LOG2-1:0] win_cnt;
  logic                win_end, base_ok, in_tol, locked_q;
  logic [CNT_W:0]      err, err_abs, tol_cnt;
  logic [GOOD_W-1:0]   good_cnt, good_next;

  always_ff @(posedge ref_clk or posedge rst)
    if (rst) ref_rst_q <= 2'b11;
    else     ref_rst_q <= {ref_rst_q[0], 1'b0};
  assign ref_rst = ref_rst_q[1];

  always_ff @(posedge ref_clk or posedge ref_rst)
    if (ref_rst) begin
      gray_s1 <= '0;
      gray_s2 <= '0;
    end else begin
      gray_s1 <= rec_gray;
      gray_s2 <= gray_s1;
    end

  always_comb begin
    cur_bin[CNT_W-1] = gray_s2[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--)
      cur_bin[i] = cur_bin[i+1] ^ gray_s2[i];
  end

  assign win_end = &win_cnt;
  assign delta   = cur_bin - prev_bin;
  assign err     = {1'b0, delta} - WIN_EXT;
  assign err_abs = err[CNT_W] ? (~err + 1'b1) : err;

  always_comb
    case (tol_sel)
      2'd0:    tol_cnt = (CNT_W+1)'(TOL0);
      2'd1:    tol_cnt = (CNT_W+1)'(TOL1);
      2'd2:    tol_cnt = (CNT_W+1)'(TOL2);
      default: tol_cnt = (CNT_W+1)'(TOL3);
    endcase

  assign in_tol    = err_abs <= tol_cnt;
  assign good_next = !in_tol ? '0 :
                     (good_cnt == GOOD_MAX) ? good_cnt : good_cnt + 1'b1;

  always_ff @(posedge ref_clk or posedge ref_rst)
    if (ref_rst) begin
      win_cnt  <= '0;
      prev_bin <= '0;
      base_ok  <= 1'b0;
      good_cnt <= '0;
      locked_q <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (win_end) begin
        prev_bin <= cur_bin;
        base_ok  <= 1'b1;
        if (base_ok) begin
          good_cnt <= good_next;
          locked_q <= good_next == GOOD_MAX;
        end
      end
    end

  assign freq_locked  = locked_q;
  assign lock_to_data = locked_q;

  assert_reset_ref_mode_R1: assert property (@(posedge ref_clk)
    ref_rst |=> !freq_locked && !lock_to_data);

  assert_change_at_window_R3: assert property (@(posedge ref_clk) disable iff (ref_rst)
    !$past(win_end) |-> $stable(freq_locked));

  assert_lock_needs_run_R4: assert property (@(posedge ref_clk) disable iff (ref_rst)
    $rose(freq_locked) |-> $past(good_cnt) == GOOD_MAX - 1'b1 && $past(in_tol));

  assert_drop_on_miss_R5: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (win_end && base_ok && !in_tol) |=> !freq_locked);

  assert_no_judge_baseline_R3: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (win_end && !base_ok) |=> !freq_locked);

endmodule

// File: tb/ppm_lock_detector_tb.sv
module ppm_lock_detector_tb;
  timeunit 1ps;
  timeprecision 100fs;

  localparam int WL = 12;
  localparam int WIN = 1 << WL;
  localparam int NV = 6;
  // table: tolerance select, recovered period in 0.1 ps, expected lock
  localparam logic [1:0] VS [NV] = '{2'd0, 2'd0,  2'd2,  2'd3,  2'd1,  2'd3};
  localparam int         VP [NV] = '{40000, 39970, 39970, 40030, 40030, 39920};
  localparam bit         VE [NV] = '{1'b1,  1'b0,  1'b0,  1'b1,  1'b0,  1'b0};

  logic ref_clk = 0, rec_clk = 0, rst = 1;
  logic [1:0] tol_sel = 2'd3;
  logic freq_locked, lock_to_data;
  real rec_half = 2000.0;
  bit  rec_on = 1;
  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  ppm_lock_detector #(.WIN_LOG2(WL), .LOCK_WINDOWS(2)) u_dut (
    .ref_clk(ref_clk), .rec_clk(rec_clk), .rst(rst), .tol_sel(tol_sel),
    .freq_locked(freq_locked), .lock_to_data(lock_to_data));

  always #2000 ref_clk = ~ref_clk;

  initial begin
    #1300;
    forever begin
      #(rec_half);
      if (rec_on) rec_clk = ~rec_clk;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_win(input real n);
    repeat (int'(n * WIN)) @(negedge ref_clk);
  endtask

  initial begin
    repeat (198000) @(posedge ref_clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge ref_clk);
    check("R1 locked in reset", freq_locked, 1'b0);
    check("R1 ref mode in reset", lock_to_data, 1'b0);
    rst = 0;
    @(negedge ref_clk);
    check("R1 locked after release", freq_locked, 1'b0);
    wait_win(2.5);
    check("R3 baseline not judged, R4 one good window", freq_locked, 1'b0);
    wait_win(1.0);
    check("R4 locked after run", freq_locked, 1'b1);
    check("R6 data mode when locked", lock_to_data, 1'b1);

    for (int i = 0; i < NV; i++) begin
      tol_sel  = VS[i];
      rec_half = VP[i] / 20.0;
      wait_win(3.5);
      check($sformatf("R2 vector %0d lock", i), freq_locked, VE[i]);
      check($sformatf("R6 vector %0d mode", i), lock_to_data, VE[i]);
    end

    tol_sel = 2'd3; rec_half = 39970 / 20.0;
    wait_win(3.5);
    check("R8 wide tolerance locks", freq_locked, 1'b1);
    tol_sel = 2'd0;
    wait_win(1.2);
    check("R8 tightened select drops", freq_locked, 1'b0);
    check("R5 back to ref mode", lock_to_data, 1'b0);

    tol_sel = 2'd3; rec_half = 2000.0;
    wait_win(3.5);
    check("R4 relock", freq_locked, 1'b1);
    rec_on = 0;
    wait_win(1.2);
    check("R7 stopped clock drops", freq_locked, 1'b0);
    wait_win(2.5);
    check("R7 stopped clock no lock", freq_locked, 1'b0);
    rec_on = 1;
    wait_win(3.5);
    check("R5 relock after restart", freq_locked, 1'b1);

    rst = 1;
    repeat (3) @(negedge ref_clk);
    check("R1 reset clears lock", freq_locked, 1'b0);
    check("R1 reset ref mode", lock_to_data, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule